// File: doc/BRIEF.md
# Dual Down-Counting Timer Peripheral with Interrupt Control

This block is a byte-wide register-mapped peripheral holding two 16-bit down-counting timers, an interrupt flag and enable pair, and two 8-bit parallel port data registers with per-bit direction masks. A host reaches it through a 4-bit register index, a write strobe, a read strobe and 8-bit write and read data. Read data is combinational from the index. Any read side effect takes place at the clock edge that ends the read cycle. The block drives one level-sensitive interrupt line.

Both counters decrement once for every clock cycle in which `tick_en` is high, so the counting rate is set outside the block. Timer one runs either one-shot or free-running with automatic reload, and its auxiliary control byte selects the mode. Timer two is always one-shot. The shift, peripheral-control and spare bytes at indices 10, 12 and 15 are plain storage. Reading index 10 still clears shift-related flag bits, but no logic in the block ever sets them.

Top module: `dual_timer_periph`

## Requirements
- R1: After reset, index 2 (port B direction) reads 0xFF, indices 6 and 7 (timer-one latch low/high) read 0xFF, index 14 reads 0x80, every other index reads 0x00 and `irq` is low.
- R2: A write to index 0 (port B) or index 1 (port A) changes only the bits whose direction bit is 1; indices 2 and 3 hold the direction masks as written. `pb_out`/`pa_out` show the data registers.
- R3: Writes to index 4 or 6 set the timer-one latch low byte, and a write to index 7 sets its high byte and clears the timer-one flag (bit 6); none of these writes changes the counter.
- R4: A write to index 5 sets the timer-one latch high byte, clears flag bit 6, loads the whole new latch into the counter and arms a one-shot event.
- R5: A counter moves only in a cycle with `tick_en` high, by one step; indices 4/5 read timer-one counter low/high, indices 8/9 timer two.
- R6: With aux (index 11) bits 7:6 other than 01, timer one sets flag bit 6 once, on the tick that brings the counter to 0 after a load, then wraps through 0xFFFF with no further flag.
- R7: With aux bits 7:6 equal to 01, timer one reloads its latch on the tick after 0xFFFF, so the flag recurs every latch+2 ticks.
- R8: A write to index 8 sets the timer-two latch low byte; a write to index 9 loads {data, latch low} into timer two, clears flag bit 5 and arms a single event on the tick reaching 0.
- R9: Reading index 4 clears flag bit 6, reading index 8 clears flag bit 5; reading index 5 or 9 clears nothing.
- R10: Writing index 13 clears each flag whose bit is 1 in the data; reading it returns the flags in bits 6:0 with bit 7 set when any flag is also enabled.
- R11: Writing index 14 with bit 7 set ORs bits 6:0 into the enables, with bit 7 clear it clears the enables written as 1; reads return bit 7 as 1.
- R12: `irq` is high exactly when a flag among bits 2, 5, 6 is set and enabled.
- R13: A timer event in the same cycle as a clear of its flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter decrement enable |
| bus_idx | input | 4 | Register index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the indexed register |
| irq | output | 1 | Level interrupt request |
| pb_out | output | 8 | Port B data register |
| pa_out | output | 8 | Port A data register |

## Verification
A wrong counter step or a wrong reload shows on the counter bytes at the first read after the faulty tick. It also shows as a flag that arrives one or two ticks early or late, so the stimulus counts ticks between successive flag events. A corrupted flag or enable bit reaches `irq` and bit 7 of the flag read in the same cycle. Flag and enable state are therefore checked after every random enable write and after every side-effecting read.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  typedef enum logic [3:0] {
    RI_PB       = 4'd0,
    RI_PA       = 4'd1,
    RI_PB_DIR   = 4'd2,
    RI_PA_DIR   = 4'd3,
    RI_T1_CLO   = 4'd4,
    RI_T1_CHI   = 4'd5,
    RI_T1_LLO   = 4'd6,
    RI_T1_LHI   = 4'd7,
    RI_T2_CLO   = 4'd8,
    RI_T2_CHI   = 4'd9,
    RI_SHIFT    = 4'd10,
    RI_AUX      = 4'd11,
    RI_PCTL     = 4'd12,
    RI_FLAGS    = 4'd13,
    RI_ENABLES  = 4'd14,
    RI_SPARE    = 4'd15
  } reg_idx_e;

  localparam int unsigned FLG_SHIFT = 2;
  localparam int unsigned FLG_T2    = 5;
  localparam int unsigned FLG_T1    = 6;
  localparam logic [1:0]  AUX_FREE_RUN = 2'b01;
endpackage

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
  parameter int unsigned CNT_W    = 16,
  parameter bit          CONT_CAP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             cont_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             cont_eff;
  logic             fire;

  generate
    if (CONT_CAP) begin : g_free_run
      assign cont_eff = cont_i;
    end else begin : g_single
      assign cont_eff = cont_i & 1'b0;
    end
  endgenerate

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    fire    = 1'b0;
    if (load_i) begin
      cnt_d   = load_val_i;
      armed_d = 1'b1;
    end else if (tick_i) begin
      if (cont_eff && (cnt_q == '1)) cnt_d = reload_i;
      else                           cnt_d = cnt_q - ONE;
      if ((cnt_d == '0) && (armed_q || cont_eff)) begin
        fire    = 1'b1;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_i || tick_i) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign fire_o = fire;

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && (cnt_q != '0) && (cnt_q != '1)) |=> (cnt_q == $past(cnt_q) - ONE));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
  p_fire_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (cnt_q == '0));
endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-2:0] set_i,
  input  logic [BYTE_W-2:0] clr_i,
  input  logic              ier_we_i,
  input  logic [BYTE_W-1:0] ier_wdata_i,
  output logic [BYTE_W-2:0] flags_o,
  output logic [BYTE_W-2:0] enables_o,
  output logic              irq_o
);
  import dtmr_pkg::*;
  localparam int unsigned NFLG = BYTE_W - 1;
  localparam logic [NFLG-1:0] SRC_MASK =
    (NFLG'(1) << FLG_SHIFT) | (NFLG'(1) << FLG_T2) | (NFLG'(1) << FLG_T1);

  logic [NFLG-1:0] flg_q, flg_d, ier_q, ier_d;

  always_comb begin
    flg_d = (flg_q & ~clr_i) | set_i;
    if (ier_wdata_i[BYTE_W-1]) ier_d = ier_q | ier_wdata_i[NFLG-1:0];
    else                       ier_d = ier_q & ~ier_wdata_i[NFLG-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      ier_q <= '0;
    end else begin
      if ((|set_i) || (|clr_i)) flg_q <= flg_d;
      if (ier_we_i)             ier_q <= ier_d;
    end
  end

  assign flags_o   = flg_q;
  assign enables_o = ier_q;
  assign irq_o     = |(flg_q & ier_q & SRC_MASK);

  p_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flg_q & $past(set_i)) == $past(set_i)));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((flg_q & $past(clr_i & ~set_i)) == '0));
  p_ier_or_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_we_i && ier_wdata_i[BYTE_W-1]) |=>
      ((ier_q & $past(ier_wdata_i[NFLG-1:0])) == $past(ier_wdata_i[NFLG-1:0])));
  p_irq_needs_pair_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((flg_q & ier_q) != '0));
endmodule

// File: rtl/dtmr_port.sv
module dtmr_port #(
  parameter int unsigned     W       = 8,
  parameter logic [W-1:0]    DIR_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dat_we_i,
  input  logic         dir_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dat_o,
  output logic [W-1:0] dir_o
);
  logic [W-1:0] dat_q, dat_d, dir_q;

  always_comb dat_d = (dat_q & ~dir_q) | (wdata_i & dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      dir_q <= DIR_RST;
    end else begin
      if (dat_we_i) dat_q <= dat_d;
      if (dir_we_i) dir_q <= wdata_i;
    end
  end

  assign dat_o = dat_q;
  assign dir_o = dir_q;

  p_dir_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dat_we_i |=> (((dat_q ^ $past(dat_q)) & ~$past(dir_q)) == '0));
endmodule

// File: rtl/dual_timer_periph.sv
module dual_timer_periph #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq,
  output logic [BYTE_W-1:0] pb_out,
  output logic [BYTE_W-1:0] pa_out
);
  import dtmr_pkg::*;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned NREG   = 1 << IDX_W;
  localparam int unsigned NFLG   = BYTE_W - 1;
  localparam int unsigned NPORT  = 2;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  reg_idx_e        idx;
  logic [NREG-1:0] wr_sel;
  assign idx    = reg_idx_e'(bus_idx);
  assign wr_sel = bus_wr ? (NREG'(1) << bus_idx) : '0;

  logic rd_t1_lo, rd_t2_lo, rd_shift;
  assign rd_t1_lo = bus_rd && (idx == RI_T1_CLO);
  assign rd_t2_lo = bus_rd && (idx == RI_T2_CLO);
  assign rd_shift = bus_rd && (idx == RI_SHIFT);

  // parallel ports: data at index p, direction at index p+2
  logic [BYTE_W-1:0] port_dat [NPORT];
  logic [BYTE_W-1:0] port_dir [NPORT];
  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      dtmr_port #(
        .W       (BYTE_W),
        .DIR_RST ((p == 0) ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}})
      ) u_port (
        .clk      (clk),
        .rst_n    (rst_sync_q),
        .dat_we_i (wr_sel[p]),
        .dir_we_i (wr_sel[p+NPORT]),
        .wdata_i  (bus_wdata),
        .dat_o    (port_dat[p]),
        .dir_o    (port_dir[p])
      );
    end
  endgenerate
  assign pb_out = port_dat[0];
  assign pa_out = port_dat[1];

  // timer latches
  logic [CNT_W-1:0] t1_lat_q, t1_lat_d, t2_lat_q, t2_lat_d;
  always_comb begin
    t1_lat_d = t1_lat_q;
    t2_lat_d = t2_lat_q;
    if (wr_sel[RI_T1_CLO] || wr_sel[RI_T1_LLO]) t1_lat_d[BYTE_W-1:0]     = bus_wdata;
    if (wr_sel[RI_T1_CHI] || wr_sel[RI_T1_LHI]) t1_lat_d[CNT_W-1:BYTE_W] = bus_wdata;
    if (wr_sel[RI_T2_CLO])                      t2_lat_d[BYTE_W-1:0]     = bus_wdata;
    if (wr_sel[RI_T2_CHI])                      t2_lat_d[CNT_W-1:BYTE_W] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      t1_lat_q <= '1;
      t2_lat_q <= '1;
    end else begin
      if (wr_sel[RI_T1_CLO] || wr_sel[RI_T1_LLO] || wr_sel[RI_T1_CHI] || wr_sel[RI_T1_LHI])
        t1_lat_q <= t1_lat_d;
      if (wr_sel[RI_T2_CLO] || wr_sel[RI_T2_CHI])
        t2_lat_q <= t2_lat_d;
    end
  end

  // storage-only bytes and aux control
  logic [BYTE_W-1:0] shift_q, aux_q, pctl_q, spare_q;
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      shift_q <= '0;
      aux_q   <= '0;
      pctl_q  <= '0;
      spare_q <= '0;
    end else begin
      if (wr_sel[RI_SHIFT]) shift_q <= bus_wdata;
      if (wr_sel[RI_AUX])   aux_q   <= bus_wdata;
      if (wr_sel[RI_PCTL])  pctl_q  <= bus_wdata;
      if (wr_sel[RI_SPARE]) spare_q <= bus_wdata;
    end
  end

  logic t1_free;
  assign t1_free = (aux_q[BYTE_W-1:BYTE_W-2] == AUX_FREE_RUN);

  logic [CNT_W-1:0] t1_cnt, t2_cnt;
  logic             t1_fire, t2_fire;

  dtmr_counter #(.CNT_W(CNT_W), .CONT_CAP(1'b1)) u_t1 (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .tick_i     (tick_en),
    .load_i     (wr_sel[RI_T1_CHI]),
    .load_val_i (t1_lat_d),
    .reload_i   (t1_lat_q),
    .cont_i     (t1_free),
    .cnt_o      (t1_cnt),
    .fire_o     (t1_fire)
  );

  dtmr_counter #(.CNT_W(CNT_W), .CONT_CAP(1'b0)) u_t2 (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .tick_i     (tick_en),
    .load_i     (wr_sel[RI_T2_CHI]),
    .load_val_i (t2_lat_d),
    .reload_i   (t2_lat_q),
    .cont_i     (1'b0),
    .cnt_o      (t2_cnt),
    .fire_o     (t2_fire)
  );

  // flag set and clear sources
  logic [NFLG-1:0] set_vec, clr_vec, flags, enables;
  always_comb begin
    set_vec         = '0;
    set_vec[FLG_T1] = t1_fire;
    set_vec[FLG_T2] = t2_fire;
    clr_vec         = '0;
    clr_vec[FLG_T1] = wr_sel[RI_T1_CHI] || wr_sel[RI_T1_LHI] || rd_t1_lo;
    clr_vec[FLG_T2] = wr_sel[RI_T2_CHI] || rd_t2_lo;
    if (rd_shift) begin
      clr_vec[FLG_SHIFT]   = 1'b1;
      clr_vec[FLG_SHIFT+1] = 1'b1;
      clr_vec[FLG_SHIFT+2] = 1'b1;
    end
    if (wr_sel[RI_FLAGS]) clr_vec = clr_vec | bus_wdata[NFLG-1:0];
  end

  dtmr_irq #(.BYTE_W(BYTE_W)) u_irq (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .set_i       (set_vec),
    .clr_i       (clr_vec),
    .ier_we_i    (wr_sel[RI_ENABLES]),
    .ier_wdata_i (bus_wdata),
    .flags_o     (flags),
    .enables_o   (enables),
    .irq_o       (irq)
  );

  always_comb begin
    case (idx)
      RI_PB:      bus_rdata = port_dat[0];
      RI_PA:      bus_rdata = port_dat[1];
      RI_PB_DIR:  bus_rdata = port_dir[0];
      RI_PA_DIR:  bus_rdata = port_dir[1];
      RI_T1_CLO:  bus_rdata = t1_cnt[BYTE_W-1:0];
      RI_T1_CHI:  bus_rdata = t1_cnt[CNT_W-1:BYTE_W];
      RI_T1_LLO:  bus_rdata = t1_lat_q[BYTE_W-1:0];
      RI_T1_LHI:  bus_rdata = t1_lat_q[CNT_W-1:BYTE_W];
      RI_T2_CLO:  bus_rdata = t2_cnt[BYTE_W-1:0];
      RI_T2_CHI:  bus_rdata = t2_cnt[CNT_W-1:BYTE_W];
      RI_SHIFT:   bus_rdata = shift_q;
      RI_AUX:     bus_rdata = aux_q;
      RI_PCTL:    bus_rdata = pctl_q;
      RI_FLAGS:   bus_rdata = {|(flags & enables), flags};
      RI_ENABLES: bus_rdata = {1'b1, enables};
      default:    bus_rdata = spare_q;
    endcase
  end

  p_t1_free_reload_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (t1_free && tick_en && !wr_sel[RI_T1_CHI] && (t1_cnt == '1)) |=> (t1_cnt == $past(t1_lat_q)));
endmodule

// File: tb/dual_timer_periph_test.sv
module dual_timer_periph_test;
  logic       clk, rst_n, tick_en, bus_wr, bus_rd;
  logic [3:0] bus_idx;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata, pb_out, pa_out;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  dual_timer_periph uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_idx(bus_idx),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .pb_out(pb_out), .pa_out(pa_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_err++;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d, input logic tk);
    @(negedge clk);
    bus_idx = i; bus_wdata = d; bus_wr = 1'b1; tick_en = tk;
    @(posedge clk); #2;
    bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] i, output logic [7:0] v);
    @(negedge clk);
    bus_idx = i; bus_rd = 1'b1;
    #3 v = bus_rdata;
    @(posedge clk); #2;
    bus_rd = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] lo_idx, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(lo_idx, lo);
    rd(lo_idx + 4'd1, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1'b1;
      @(posedge clk); #2; tick_en = 1'b0;
    end
  endtask

  task automatic ticks_to_flag(input int bitn, output int n);
    logic [7:0] v;
    n = 0;
    for (int k = 0; k < 400; k++) begin
      ticks(1);
      n++;
      rd(4'd13, v);
      if (v[bitn]) break;
    end
  endtask

  function automatic logic [7:0] reset_val(input int i);
    case (i)
      2, 6, 7: return 8'hFF;
      14:      return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    logic [7:0]  v, dir, d;
    logic [15:0] c;
    logic [7:0]  pm [2];
    logic [6:0]  ier_m;
    int          L, M, n, p;
    void'($urandom(32'd24681357));
    rst_n = 1'b0; tick_en = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_idx = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;

    // R1 reset values
    chk("R1 irq", {15'd0, irq}, 16'd0);
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), v);
      chk($sformatf("R1 idx%0d", i), {8'd0, v}, {8'd0, reset_val(i)});
    end

    // R2 port writes guarded by direction
    pm[0] = 8'h00; pm[1] = 8'h00;
    for (int k = 0; k < 12; k++) begin
      p   = int'($urandom % 2);
      dir = 8'($urandom);
      d   = 8'($urandom);
      wr(4'(p + 2), dir, 1'b0);
      wr(4'(p), d, 1'b0);
      pm[p] = (pm[p] & ~dir) | (d & dir);
      rd(4'(p), v);
      chk("R2 data readback", {8'd0, v}, {8'd0, pm[p]});
      rd(4'(p + 2), v);
      chk("R2 dir readback", {8'd0, v}, {8'd0, dir});
    end
    chk("R2 pb_out", {8'd0, pb_out}, {8'd0, pm[0]});
    chk("R2 pa_out", {8'd0, pa_out}, {8'd0, pm[1]});

    // R4 R5 R6 timer one single event
    wr(4'd14, 8'hC0, 1'b0);
    ier_m = 7'h40;
    L = 3 + int'($urandom % 20);
    wr(4'd6, 8'(L), 1'b0);
    wr(4'd5, 8'h00, 1'b0);
    rd(4'd6, v); chk("R4 latch low", {8'd0, v}, 16'(L));
    rd(4'd7, v); chk("R4 latch high", {8'd0, v}, 16'd0);
    rd16(4'd4, c); chk("R4 counter loaded", c, 16'(L));
    repeat (3) @(posedge clk);
    #2;
    rd16(4'd4, c); chk("R5 hold without tick", c, 16'(L));
    ticks(L - 1);
    rd16(4'd4, c); chk("R5 one step per tick", c, 16'd1);
    chk("R6 no flag before zero", {15'd0, irq}, 16'd0);
    ticks(1);
    chk("R12 irq on enabled flag", {15'd0, irq}, 16'd1);
    rd(4'd13, v); chk("R10 flag read with summary bit", {8'd0, v}, 16'h00C0);
    rd(4'd5, v); chk("R9 high byte read", {8'd0, v}, 16'd0);
    chk("R9 high read keeps flag", {15'd0, irq}, 16'd1);
    rd(4'd4, v); chk("R6 counter at zero", {8'd0, v}, 16'd0);
    chk("R9 low read clears flag", {15'd0, irq}, 16'd0);
    ticks(1);
    rd16(4'd4, c); chk("R6 wrap", c, 16'hFFFF);
    ticks(3);
    rd16(4'd4, c); chk("R6 keeps counting", c, 16'hFFFC);
    rd(4'd13, v); chk("R6 no second flag", {8'd0, v}, 16'd0);

    // R3 latch-only writes
    wr(4'd4, 8'h55, 1'b0);
    wr(4'd7, 8'h12, 1'b0);
    rd(4'd6, v); chk("R3 latch low via idx4", {8'd0, v}, 16'h55);
    rd(4'd7, v); chk("R3 latch high", {8'd0, v}, 16'h12);
    rd16(4'd4, c); chk("R3 counter untouched", c, 16'hFFFC);

    // R7 free-running mode
    wr(4'd11, 8'h40, 1'b0);
    rd(4'd11, v); chk("R7 aux readback", {8'd0, v}, 16'h40);
    L = 2 + int'($urandom % 10);
    wr(4'd6, 8'(L), 1'b0);
    wr(4'd5, 8'h00, 1'b0);
    ticks_to_flag(6, n);
    chk("R7 first event after latch ticks", 16'(n), 16'(L));
    wr(4'd13, 8'h40, 1'b0);
    rd(4'd13, v); chk("R10 write clears flag", {8'd0, v}, 16'd0);
    ticks(1);
    rd16(4'd4, c); chk("R7 passes FFFF", c, 16'hFFFF);
    ticks(1);
    rd16(4'd4, c); chk("R7 reload", c, 16'(L));
    ticks_to_flag(6, n);
    chk("R7 period latch+2", 16'(n + 2), 16'(L + 2));
    wr(4'd7, 8'h00, 1'b0);
    rd(4'd13, v); chk("R3 high latch write clears flag", {8'd0, v}, 16'd0);
    rd16(4'd4, c); chk("R3 counter kept at zero", c, 16'd0);

    // R13 event beats simultaneous clear
    ticks(2);
    ticks(L - 1);
    rd16(4'd4, c); chk("R13 setup count", c, 16'd1);
    wr(4'd13, 8'h40, 1'b1);
    rd(4'd13, v); chk("R13 flag survives clear", {8'd0, v}, 16'h00C0);

    // R8 timer two
    wr(4'd14, 8'hA0, 1'b0);
    ier_m = ier_m | 7'h20;
    rd(4'd14, v); chk("R11 enable read", {8'd0, v}, 16'h00E0);
    M = 2 + int'($urandom % 15);
    wr(4'd8, 8'(M), 1'b0);
    wr(4'd9, 8'h00, 1'b0);
    rd16(4'd8, c); chk("R8 load", c, 16'(M));
    ticks(M - 1);
    rd(4'd13, v); chk("R8 no flag before zero", {15'd0, v[5]}, 16'd0);
    ticks(1);
    rd(4'd9, v); chk("R8 counter high at zero", {8'd0, v}, 16'd0);
    wr(4'd13, 8'h40, 1'b0);
    rd(4'd13, v); chk("R10 selective clear", {8'd0, v}, 16'h00A0);

    // R11 R12 random enable writes with two flags pending
    ticks_to_flag(6, n);
    rd(4'd13, v); chk("R10 both flags", {9'd0, v[6:0]}, 16'h0060);
    for (int k = 0; k < 16; k++) begin
      d = 8'($urandom);
      if (k == 14) d = 8'h7F;
      if (k == 15) d = 8'h84;
      wr(4'd14, d, 1'b0);
      if (d[7]) ier_m = ier_m | d[6:0];
      else      ier_m = ier_m & ~d[6:0];
      rd(4'd14, v); chk("R11 enable model", {8'd0, v}, {8'd0, 1'b1, ier_m});
      chk("R12 irq level", {15'd0, irq}, {15'd0, |(7'h60 & ier_m & 7'h64)});
      rd(4'd13, v); chk("R10 summary bit", {8'd0, v}, {8'd0, |(7'h60 & ier_m), 7'h60});
    end

    // R9 timer two low read clears its flag
    rd(4'd8, v);
    rd(4'd13, v); chk("R9 low read clears timer two flag", {9'd0, v[6:0]}, 16'h0040);
    ticks(5);
    rd(4'd13, v); chk("R8 single event only", {15'd0, v[5]}, 16'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule